// File: doc/BRIEF.md
# Multi-Lane SPI Phase Sequencer

This block is the master-side engine of a serial flash style SPI port. Each transaction it runs is made of up to four phases in a fixed sequence: command, address, dummy and data. The data phase either sends a write word or captures a read word. Each of the command, address and data phases picks its own width of 1, 2, 4 or 8 lines. One bit-order choice covers every outgoing phase and a second covers the incoming read data. A phase whose length is zero is skipped.

A 14-bit control word holds the lane widths, the two bit orders, a choice to keep the bus driven through dummy cycles, and the levels that the hold and write-protect outputs rest at between transactions. The control word can only be written while the sequencer is idle.

The host sets the phase lengths, the command, address and write words and the read/write choice, then pulses `start`. The block frames the transfer with an active-low chip select. It clocks SCLK in mode 0 at half the system clock rate, and it pulses `done` when the transfer completes. At that point `rdata` holds the captured read word. Lengths are given in bits for the command, address and data phases, and must be a multiple of that phase's lane count. The dummy length is given in SCLK cycles.

Top module: `spi_phase_seq`

## Requirements
- R1: While reset is held and after it is released, cs_n=1, sclk=0, io_oe=0, done=0 and busy=0. The control word resets to 14'h3000, so hold_line and wprot_line are both 1.
- R2: Phases run in the order command, address, dummy, data. A phase with zero length produces no SCLK cycles. The number of SCLK rising edges equals cmd/Lc + addr/La + dummy + data/Ld. When every length is zero, done is raised with no SCLK edge at all.
- R3: Control bits [2:0] = {octal, quad, dual} select the command lane count. Octal (8 lines) beats quad (4), quad beats dual (2), and none set means 1 line.
- R4: Control bits [5:3] select the address lane count with the same encoding and priority, independently of the command phase.
- R5: Control bits [8:6] select the data-phase lane count with the same encoding, for both read and write data. During read data, io_oe is 0.
- R6: Control bit 9 sets the outgoing order. With 0 (MSB first), group j of an n-bit phase with L lanes puts value bit n-L-jL+k on line k. With 1 (LSB first), it puts value bit jL+k on line k. While a phase with L lanes drives, io_oe holds the low L bits set.
- R7: Control bit 10 sets the incoming order. With 0, line k of received group j lands in rdata bit n-L-jL+k. With 1, it lands in bit jL+k. Bits of rdata above n are 0.
- R8: Control bit 11 selects dummy behaviour. With 0, io_oe is 0 during every dummy cycle. With 1, all eight lines are driven (io_oe=8'hFF) with io_out=0.
- R9: Between transactions, hold_line equals control bit 12 and wprot_line equals control bit 13.
- R10: A control write is ignored while busy is 1 and in the cycle where start is accepted. This includes lane widths and idle levels.
- R11: cs_n is low at every SCLK rising edge of a transaction, and sclk is 0 whenever cs_n is 1. Outputs change while SCLK falls. Inputs are sampled as SCLK rises. In single-line mode, line 0 carries outgoing data and line 1 is the incoming line.
- R12: done is high for exactly one cycle per transaction, in the cycle where cs_n returns high. rdata is valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 14 | Control word value |
| start | input | 1 | Begin a transaction (taken when idle) |
| rd_op | input | 1 | 1 = data phase reads, 0 = data phase writes |
| cmd_bits | input | 5 | Command length in bits (0 skips) |
| addr_bits | input | 6 | Address length in bits (0 skips) |
| dummy_cycles | input | 5 | Dummy length in SCLK cycles (0 skips) |
| data_bits | input | 6 | Data length in bits (0 skips) |
| cmd_word | input | 16 | Command value, right aligned |
| addr_word | input | 32 | Address value, right aligned |
| wdata | input | 32 | Write data value, right aligned |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Captured read data, right aligned |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| hold_line | output | 1 | Hold output: idle level from control word, high while active |
| wprot_line | output | 1 | Write-protect output: idle level from control word, high while active |
| io_out | output | 8 | Data line output values |
| io_oe | output | 8 | Per-line output enables |
| io_in | input | 8 | Data line input values |

## Verification
The hardest state to reach from the ports is a control write landing in the middle of a running transfer, or in the very cycle start is accepted. The only sign that such a write was rejected is that the lane widths and idle levels it would have changed stay as they were. The bench pulses a write in both of those cycles. The write asks for octal commands and low idle levels. The bench then checks that the SCLK count still matches a single-line command and that hold and write-protect come back high. A bench-side serial model records every SCLK rising edge and feeds a distinct byte per slot on the input lines. This lets the bench check the lane mapping, the bit order and the priority of the width bits slot by slot.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

    localparam int CFG_W = 14;

    localparam logic [CFG_W-1:0] CFG_RESET = 14'h3000;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_DATA  = 3'd3,
        PH_NONE  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } state_e;

    // width fields are {octal, quad, dual}
    typedef struct packed {
        logic       wp_idle;
        logic       hold_idle;
        logic       dummy_drive;
        logic       rx_lsb;
        logic       tx_lsb;
        logic [2:0] data_w;
        logic [2:0] addr_w;
        logic [2:0] cmd_w;
    } ctrl_t;

    function automatic logic [3:0] lanes_of(input logic [2:0] w);
        if (w[2]) return 4'd8;
        if (w[1]) return 4'd4;
        if (w[0]) return 4'd2;
        return 4'd1;
    endfunction

endpackage

// File: rtl/spiseq_cfg.sv
module spiseq_cfg
    import spiseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             locked,
    output ctrl_t            ctrl
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= ctrl_t'(CFG_RESET);
        else if (wr_en && !locked)
            ctrl <= ctrl_t'(wr_data);
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(ctrl)); // R10

endmodule

// File: rtl/spiseq_tx.sv
module spiseq_tx #(
    parameter int SH_W  = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic             lsb_first,
    input  logic [3:0]       lanes,
    input  logic [SH_W-1:0]  val,
    input  logic [CNT_W-1:0] len,
    output logic [7:0]       lines
);

    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (load)
            sh <= lsb_first ? val : (val << (SH_W - int'(len)));
        else if (shift)
            sh <= lsb_first ? (sh >> lanes) : (sh << lanes);
    end

    always_comb begin
        lines = '0;
        for (int k = 0; k < 8; k++) begin
            if (4'(k) < lanes)
                lines[k] = lsb_first ? sh[k] : sh[SH_W - int'(lanes) + k];
        end
    end

endmodule

// File: rtl/spiseq_rx.sv
module spiseq_rx #(
    parameter int SH_W  = 32,
    parameter int CNT_W = 6,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             capture,
    input  logic             lsb_first,
    input  logic [3:0]       lanes,
    input  logic [7:0]       io_in,
    input  logic [CNT_W-1:0] len,
    output logic [OUT_W-1:0] word
);

    logic [SH_W-1:0] acc;
    logic [7:0]      grp;

    always_comb begin
        grp = '0;
        if (lanes == 4'd1)
            grp[0] = io_in[1];
        else
            for (int k = 0; k < 8; k++)
                if (4'(k) < lanes) grp[k] = io_in[k];
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (capture)
            acc <= lsb_first ? ((acc >> lanes) | (SH_W'(grp) << (SH_W - int'(lanes))))
                             : ((acc << lanes) | SH_W'(grp));
    end

    always_comb
        word = OUT_W'(lsb_first ? (acc >> (SH_W - int'(len))) : acc);

endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
    import spiseq_pkg::*;
#(
    parameter int CMD_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int DMY_W   = 5,
    localparam int CL_W   = $clog2(CMD_W + 1),
    localparam int AL_W   = $clog2(ADDR_W + 1),
    localparam int DL_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    input  logic              rd_op,
    input  logic [CL_W-1:0]   cmd_bits,
    input  logic [AL_W-1:0]   addr_bits,
    input  logic [DMY_W-1:0]  dummy_cycles,
    input  logic [DL_W-1:0]   data_bits,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [ADDR_W-1:0] addr_word,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              hold_line,
    output logic              wprot_line,
    output logic [7:0]        io_out,
    output logic [7:0]        io_oe,
    input  logic [7:0]        io_in
);

    localparam int SH_A  = (CMD_W > ADDR_W) ? CMD_W : ADDR_W;
    localparam int SH_W  = (SH_A > DATA_W) ? SH_A : DATA_W;
    localparam int LEN_W = $clog2(SH_W + 1);
    localparam int CNT_W = (LEN_W > DMY_W) ? LEN_W : DMY_W;

    state_e           state;
    phase_e           phase, tgt;
    logic             half, rd_q;
    logic [CNT_W-1:0] cnt, tgt_len;
    logic [CNT_W-1:0] q_lc, q_la, q_ld, q_dm, s_lc, s_la, s_ld, s_dm;
    logic [SH_W-1:0]  q_cmd, q_addr, q_dat, s_cmd, s_addr, s_dat, tgt_val;
    logic [3:0]       nz, cur_lanes;
    logic [7:0]       tx_lines, lane_mask;
    logic [DATA_W-1:0] rx_word;
    logic             last_slot, tx_load, tx_shift, rx_cap, cfg_lock;
    ctrl_t            ctrl;

    function automatic phase_e pick(input phase_e from, input logic [3:0] nzv);
        for (int i = 0; i < 4; i++)
            if (i >= int'(from) && nzv[i]) return phase_e'(i);
        return PH_NONE;
    endfunction

    assign busy     = (state != ST_IDLE);
    assign cfg_lock = busy || start;

    spiseq_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .locked(cfg_lock), .ctrl(ctrl)
    );

    // source of phase settings: live inputs when idle, latched copy when running
    always_comb begin
        if (state == ST_IDLE) begin
            s_cmd  = SH_W'(cmd_word);
            s_addr = SH_W'(addr_word);
            s_dat  = SH_W'(wdata);
            s_lc   = CNT_W'(cmd_bits);
            s_la   = CNT_W'(addr_bits);
            s_ld   = CNT_W'(data_bits);
            s_dm   = CNT_W'(dummy_cycles);
        end else begin
            s_cmd = q_cmd; s_addr = q_addr; s_dat = q_dat;
            s_lc  = q_lc;  s_la   = q_la;   s_ld  = q_ld;  s_dm = q_dm;
        end
        nz  = {s_ld != '0, s_dm != '0, s_la != '0, s_lc != '0};
        tgt = pick((state == ST_IDLE) ? PH_CMD : phase_e'(phase + 3'd1), nz);
        case (tgt)
            PH_CMD:   begin tgt_len = s_lc; tgt_val = s_cmd;  end
            PH_ADDR:  begin tgt_len = s_la; tgt_val = s_addr; end
            PH_DUMMY: begin tgt_len = s_dm; tgt_val = '0;     end
            PH_DATA:  begin tgt_len = s_ld; tgt_val = s_dat;  end
            default:  begin tgt_len = '0;   tgt_val = '0;     end
        endcase
    end

    always_comb begin
        case (phase)
            PH_CMD:  cur_lanes = lanes_of(ctrl.cmd_w);
            PH_ADDR: cur_lanes = lanes_of(ctrl.addr_w);
            PH_DATA: cur_lanes = lanes_of(ctrl.data_w);
            default: cur_lanes = 4'd1;
        endcase
        lane_mask = 8'((9'd1 << cur_lanes) - 9'd1);
    end

    assign last_slot = (cnt <= CNT_W'(cur_lanes));
    assign tx_load   = ((state == ST_IDLE) && start) || ((state == ST_RUN) && half && last_slot);
    assign tx_shift  = (state == ST_RUN) && half;
    assign rx_cap    = (state == ST_RUN) && !half && (phase == PH_DATA) && rd_q;

    spiseq_tx #(.SH_W(SH_W), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .shift(tx_shift),
        .lsb_first(ctrl.tx_lsb), .lanes(cur_lanes), .val(tgt_val),
        .len(tgt_len), .lines(tx_lines)
    );

    spiseq_rx #(.SH_W(SH_W), .CNT_W(CNT_W), .OUT_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .clear((state == ST_IDLE) && start),
        .capture(rx_cap), .lsb_first(ctrl.rx_lsb),
        .lanes(lanes_of(ctrl.data_w)), .io_in(io_in), .len(q_ld),
        .word(rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_NONE;
            half  <= 1'b0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
            cnt   <= '0;
            rd_q  <= 1'b0;
            rdata <= '0;
            q_cmd <= '0; q_addr <= '0; q_dat <= '0;
            q_lc  <= '0; q_la   <= '0; q_ld  <= '0; q_dm <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    q_cmd <= s_cmd; q_addr <= s_addr; q_dat <= s_dat;
                    q_lc  <= s_lc;  q_la   <= s_la;   q_ld  <= s_ld;  q_dm <= s_dm;
                    rd_q  <= rd_op;
                    cs_n  <= 1'b0;
                    half  <= 1'b0;
                    phase <= tgt;
                    cnt   <= tgt_len;
                    state <= (tgt == PH_NONE) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    half <= !half;
                    sclk <= !half;
                    if (half) begin
                        if (last_slot) begin
                            phase <= tgt;
                            cnt   <= tgt_len;
                            if (tgt == PH_NONE) state <= ST_FIN;
                        end else begin
                            cnt <= cnt - CNT_W'(cur_lanes);
                        end
                    end
                end
                default: begin
                    cs_n  <= 1'b1;
                    done  <= 1'b1;
                    phase <= PH_NONE;
                    rdata <= rx_word;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        io_out = '0;
        io_oe  = '0;
        if (state == ST_RUN) begin
            case (phase)
                PH_CMD, PH_ADDR: begin io_out = tx_lines; io_oe = lane_mask; end
                PH_DATA: if (!rd_q) begin io_out = tx_lines; io_oe = lane_mask; end
                PH_DUMMY: if (ctrl.dummy_drive) io_oe = 8'hFF;
                default: ;
            endcase
        end
    end

    assign hold_line  = busy ? 1'b1 : ctrl.hold_idle;
    assign wprot_line = busy ? 1'b1 : ctrl.wp_idle;

    AST_CS_FRAMES: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> !cs_n); // R11
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_DONE_WITH_CS: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n); // R12
    AST_DUMMY_HIZ: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && phase == PH_DUMMY && !ctrl.dummy_drive) |-> (io_oe == 8'h00)); // R8
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (rx_cap || (sclk && phase == PH_DATA && rd_q)) |-> (io_oe == 8'h00)); // R5
    AST_OE_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && phase != PH_DUMMY) |-> $onehot0(io_oe + 8'd1)); // R6

endmodule

// File: tb/spi_phase_seq_tb.sv
module spi_phase_seq_tb;

    typedef struct packed {
        logic [13:0] cfg;
        logic        rd;
        logic [4:0]  cl;
        logic [5:0]  al;
        logic [4:0]  dm;
        logic [5:0]  dl;
        logic [15:0] cmd;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [7:0]  exp_slots;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{14'h3000, 1'b0, 5'd8,  6'd24, 5'd0, 6'd8,  16'h009F, 32'h00123456, 32'h000000C3, 8'd40},
        '{14'h3400, 1'b1, 5'd8,  6'd24, 5'd0, 6'd16, 16'h0003, 32'h00ABCDEF, 32'h00000000, 8'd48},
        '{14'h3092, 1'b1, 5'd8,  6'd24, 5'd6, 6'd32, 16'h00EB, 32'h00FEDCBA, 32'h00000000, 8'd22},
        '{14'h3B0F, 1'b0, 5'd16, 6'd32, 5'd4, 6'd32, 16'hA55A, 32'h89ABCDEF, 32'h13579BDF, 8'd26},
        '{14'h3440, 1'b1, 5'd0,  6'd0,  5'd3, 6'd8,  16'h0000, 32'h00000000, 32'h00000000, 8'd7},
        '{14'h30C3, 1'b0, 5'd8,  6'd0,  5'd0, 6'd16, 16'h0038, 32'h00000000, 32'h0000BEEF, 8'd6},
        '{14'h3000, 1'b0, 5'd0,  6'd0,  5'd0, 6'd0,  16'h0000, 32'h00000000, 32'h00000000, 8'd0},
        '{14'h3771, 1'b1, 5'd8,  6'd32, 5'd2, 6'd8,  16'h00C5, 32'h0F1E2D3C, 32'h00000000, 8'd11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        rd_op = 1'b0;
    logic [4:0]  cmd_bits = '0;
    logic [5:0]  addr_bits = '0;
    logic [4:0]  dummy_cycles = '0;
    logic [5:0]  data_bits = '0;
    logic [15:0] cmd_word = '0;
    logic [31:0] addr_word = '0;
    logic [31:0] wdata = '0;
    logic        busy, done, sclk, cs_n, hold_line, wprot_line;
    logic [31:0] rdata;
    logic [7:0]  io_out, io_oe;
    logic [7:0]  io_in = '0;

    int nchk = 0;
    int nfail = 0;
    int nsl = 0;
    int done_cnt = 0;
    int cs_bad = 0;
    bit prev_sclk = 1'b0;
    bit finished = 1'b0;
    logic [7:0] slot_out [0:127];
    logic [7:0] slot_oe  [0:127];

    spi_phase_seq u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .start(start), .rd_op(rd_op), .cmd_bits(cmd_bits), .addr_bits(addr_bits),
        .dummy_cycles(dummy_cycles), .data_bits(data_bits), .cmd_word(cmd_word),
        .addr_word(addr_word), .wdata(wdata), .busy(busy), .done(done),
        .rdata(rdata), .sclk(sclk), .cs_n(cs_n), .hold_line(hold_line),
        .wprot_line(wprot_line), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    initial forever #5 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 29 + 91) ^ 8'h3C;
    endfunction

    function automatic int lanes_for(input logic [2:0] w);
        if (w[2]) return 8;
        if (w[1]) return 4;
        if (w[0]) return 2;
        return 1;
    endfunction

    // serial-side model: records each SCLK rise, feeds one byte per slot
    initial forever begin
        @(negedge clk);
        if (sclk && !prev_sclk) begin
            if (nsl < 128) begin
                slot_out[nsl] = io_out;
                slot_oe[nsl]  = io_oe;
            end
            if (cs_n) cs_bad++;
            nsl++;
        end
        if (sclk && cs_n) cs_bad++;
        if (done) done_cnt++;
        prev_sclk = sclk;
        io_in = pat(nsl);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_tx(input string req, input int base, input int n, input int L,
                            input logic [31:0] val, input bit lsb);
        logic [7:0] msk, exp_o;
        logic [7:0] bad_a = '0, bad_e = '0;
        bit ok = 1'b1;
        msk = 8'((9'd1 << L) - 9'd1);
        for (int j = 0; j < n / L; j++) begin
            exp_o = '0;
            for (int k = 0; k < L; k++)
                exp_o[k] = val[lsb ? (j * L + k) : (n - L - j * L + k)];
            if (ok && ((slot_out[base + j] & msk) !== exp_o || slot_oe[base + j] !== msk)) begin
                ok = 1'b0;
                bad_a = slot_out[base + j];
                bad_e = exp_o;
            end
        end
        chk(ok, req, "tx lanes/order", {24'h0, bad_a}, {24'h0, bad_e});
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int lc, la, ld, base, cyc;
        logic [31:0] exp_rd;
        logic [7:0] g, mk;
        bit ok;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v.cfg;
        @(negedge clk);
        cfg_we = 1'b0;
        nsl = 0; done_cnt = 0; cs_bad = 0;
        rd_op = v.rd; cmd_bits = v.cl; addr_bits = v.al; dummy_cycles = v.dm;
        data_bits = v.dl; cmd_word = v.cmd; addr_word = v.addr; wdata = v.wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        chk(done === 1'b1, "R12", $sformatf("vec %0d done seen", idx), {31'h0, done}, 32'h1);
        chk(cs_n === 1'b1, "R12", "cs_n high with done", {31'h0, cs_n}, 32'h1);
        @(negedge clk); @(negedge clk);
        chk(done_cnt == 1, "R12", "done pulse width", done_cnt, 1);
        chk(nsl == int'(v.exp_slots), "R2", $sformatf("vec %0d SCLK count", idx), nsl, v.exp_slots);
        chk(cs_bad == 0, "R11", "cs_n low at every SCLK rise", cs_bad, 0);
        lc = lanes_for(v.cfg[2:0]);
        la = lanes_for(v.cfg[5:3]);
        ld = lanes_for(v.cfg[8:6]);
        base = 0;
        if (v.cl != 0) check_tx("R3", base, int'(v.cl), lc, {16'h0, v.cmd}, v.cfg[9]);
        base += int'(v.cl) / lc;
        if (v.al != 0) check_tx("R4", base, int'(v.al), la, v.addr, v.cfg[9]);
        base += int'(v.al) / la;
        if (v.dm != 0) begin
            ok = 1'b1;
            for (int j = 0; j < int'(v.dm); j++)
                if (slot_oe[base + j] !== (v.cfg[11] ? 8'hFF : 8'h00) ||
                    (v.cfg[11] && slot_out[base + j] !== 8'h00)) ok = 1'b0;
            chk(ok, "R8", "dummy line drive", {24'h0, slot_oe[base]}, v.cfg[11] ? 32'hFF : 32'h0);
        end
        base += int'(v.dm);
        if (v.dl != 0) begin
            if (!v.rd) check_tx("R6", base, int'(v.dl), ld, v.wd, v.cfg[9]);
            else begin
                exp_rd = '0;
                ok = 1'b1;
                mk = 8'((9'd1 << ld) - 9'd1);
                for (int j = 0; j < int'(v.dl) / ld; j++) begin
                    g = (ld == 1) ? {7'h0, pat(base + j) >> 1} & 8'h01 : (pat(base + j) & mk);
                    for (int k = 0; k < ld; k++)
                        exp_rd[v.cfg[10] ? (j * ld + k) : (int'(v.dl) - ld - j * ld + k)] = g[k];
                    if (slot_oe[base + j] !== 8'h00) ok = 1'b0;
                end
                chk(ok, "R5", "read phase released", {24'h0, slot_oe[base]}, 32'h0);
                chk(rdata === exp_rd, "R7", $sformatf("vec %0d read word", idx), rdata, exp_rd);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && io_oe === 8'h00, "R1", "pins in reset",
            {22'h0, cs_n, sclk, io_oe}, {22'h0, 2'b10, 8'h00});
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0 && cs_n === 1'b1, "R1", "after reset",
            {29'h0, done, busy, cs_n}, 32'h1);
        chk(hold_line === 1'b1 && wprot_line === 1'b1, "R1", "idle levels after reset",
            {30'h0, hold_line, wprot_line}, 32'h3);

        // R9: idle levels follow the control word
        cfg_we = 1'b1; cfg_wdata = 14'h2000;
        @(negedge clk); cfg_we = 1'b0; @(negedge clk);
        chk(hold_line === 1'b0 && wprot_line === 1'b1, "R9", "hold low wp high",
            {30'h0, hold_line, wprot_line}, 32'h1);
        cfg_we = 1'b1; cfg_wdata = 14'h1000;
        @(negedge clk); cfg_we = 1'b0; @(negedge clk);
        chk(hold_line === 1'b1 && wprot_line === 1'b0, "R9", "hold high wp low",
            {30'h0, hold_line, wprot_line}, 32'h2);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: writes during start cycle and mid-run are dropped
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 14'h3000;
        @(negedge clk);
        nsl = 0; done_cnt = 0;
        rd_op = 1'b0; cmd_bits = 5'd8; addr_bits = '0; dummy_cycles = '0; data_bits = '0;
        cmd_word = 16'h00A6; cfg_wdata = 14'h0007; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cfg_we = 1'b0;
        repeat (4) @(negedge clk);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk); @(negedge clk);
        chk(nsl == 8, "R10", "width unchanged by blocked write", nsl, 8);
        chk(hold_line === 1'b1 && wprot_line === 1'b1, "R10", "idle levels unchanged",
            {30'h0, hold_line, wprot_line}, 32'h3);
        check_tx("R11", 0, 8, 1, 32'h000000A6, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule